// File: doc/BRIEF.md
# DSL Front-End Serial Frame Port

This block is the digital serial port of a line-interface front end for a symmetric DSL modem. It runs on an oversampling clock at 48 times the symbol rate. A symbol-rate baud strobe from the signal processor keeps it aligned. Every symbol period it sends one 48-bit frame on a single output pin. The frame carries two 14-bit two's-complement converter samples taken from parallel inputs. Each sample is padded to 16 bits and followed by a run of eight idle-high bits. The output pin changes only on the falling clock edge, so the receiver can sample it on the rising edge.

In the same frame, the port takes in a 16-bit control word on a serial input and decodes it into five settings: transmit enable, a four-level transmit symbol, receive gain in 3 dB steps (with reserved codes flagged), loopback and transmit boost. The samples and the decoded settings change only at a frame boundary. Downstream logic therefore never sees a partly shifted value. A baud edge that lands in the middle of a frame restarts the frame and raises a one-cycle error pulse.

Top module: `afe_serial_port`

## Requirements
- R1: A bit counter steps through counts 0 to 47, one count per rising clock edge. It returns to 0 after 47, so a free-running frame is exactly 48 bit times long.
- R2: Counts 0–15 carry the first 16-bit word, MSB first. Counts 24–39 carry the second word, MSB first. Within each word, bits 15..2 are the 14-bit two's-complement sample (0x1FFF is positive full scale, 0x0000 is mid scale, 0x2000 is negative full scale).
- R3: Bits 1 and 0 of each word (counts 14, 15, 38, 39) are driven low.
- R4: Counts 16–23 and 40–47 are driven high.
- R5: `sdo_o` changes only on the falling edge of `clk_i`. Bit time n appears after the falling edge that follows the rising edge that set count n.
- R6: `sample_a_i` and `sample_b_i` are captured only on the rising edge that starts a frame (count becomes 0). A change to them mid-frame does not alter the frame in progress.
- R7: `sdi_i` is sampled on the rising edge that ends each of counts 0–15 and shifted in MSB first. The decoded outputs update only on the frame-start edge. Word bits 7..0 have no effect.
- R8: Word bit 15 drives `tx_en_o`. When it is 0, `tx_level_o` is 0 whatever bits 14:13 hold.
- R9: With bit 15 set, bits 14:13 give `tx_level_o` (3-bit two's complement) as follows: 00 → −3, 01 → −1, 11 → +1, 10 → +3.
- R10: Bits 12:10 codes 0–4 give `rx_gain_db_o` = 3 × code, with `gain_rsvd_o` = 0. Codes 5–7 give `gain_rsvd_o` = 1 and `rx_gain_db_o` = 0.
- R11: Bit 9 drives `loopback_o` and bit 8 drives `boost_o`.
- R12: A rising `baud_i` passes through two flip-flops. Count 0 then starts on the second rising clock edge after `baud_i` goes high, and that edge also captures the samples and decodes the control word.
- R13: `sync_err_o` pulses high for one cycle, together with count 0, when a baud edge is detected while the count is neither 0 nor 47.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oversampling clock, 48x symbol rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| baud_i | input | 1 | Symbol-rate alignment strobe |
| sample_a_i | input | 14 | First converter sample of the period |
| sample_b_i | input | 14 | Second converter sample of the period |
| sdi_i | input | 1 | Serial control word input |
| sdo_o | output | 1 | Serial frame output |
| sync_err_o | output | 1 | Misaligned baud edge pulse |
| tx_en_o | output | 1 | Transmit enable |
| tx_level_o | output | 3 | Transmit symbol level, two's complement |
| rx_gain_db_o | output | 4 | Receive gain in dB |
| gain_rsvd_o | output | 1 | Reserved gain code received |
| loopback_o | output | 1 | Loopback enable |
| boost_o | output | 1 | Transmit boost enable |

## Verification
Two events can fall on the same rising edge: the counter's own wrap from 47 to 0, and a synchronized baud edge. The bench provokes this by raising the baud strobe so that its detection lands on count 47. It then expects an ordinary 48-bit frame with no error pulse. In a second case the baud strobe is raised at count 20. The bench expects count 0 and the error pulse together on the second edge after the strobe rises, along with fresh sample capture and fresh control decode. It judges this through the bits of the following frame and the decoded outputs.

// File: rtl/afe_port_pkg.sv
package afe_port_pkg;
  localparam int unsigned SAMPLE_W  = 14;
  localparam int unsigned WORD_W    = 16;
  localparam int unsigned GAP_W     = 8;
  localparam int unsigned FRAME_LEN = 2 * (WORD_W + GAP_W);
  localparam int unsigned GAIN_W    = 4;

  typedef struct packed {
    logic              tx_en;
    logic [2:0]        tx_level;
    logic [GAIN_W-1:0] gain_db;
    logic              gain_rsvd;
    logic              loopback;
    logic              boost;
  } ctrl_t;
endpackage

// File: rtl/afe_frame_timer.sv
module afe_frame_timer #(
  parameter  int unsigned FRAME_LEN = 48,
  localparam int unsigned CNT_W     = $clog2(FRAME_LEN)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             baud_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             boundary_o,
  output logic             sync_err_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_LEN - 1);

  logic [1:0] baud_q;
  logic       baud_rise;

  assign baud_rise  = baud_q[0] & ~baud_q[1];
  assign boundary_o = baud_rise | (cnt_o == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      baud_q     <= '0;
      cnt_o      <= '0;
      sync_err_o <= 1'b0;
    end else begin
      baud_q     <= {baud_q[0], baud_i};
      cnt_o      <= boundary_o ? '0 : cnt_o + 1'b1;
      sync_err_o <= baud_rise && (cnt_o != '0) && (cnt_o != LAST);
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_o <= LAST); // R1
  AST_CNT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o == LAST) |=> (cnt_o == '0)); // R1
  AST_ERR_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_err_o |-> (cnt_o == '0)); // R13
  AST_ERR_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_err_o |=> !sync_err_o); // R13
endmodule

// File: rtl/afe_tx_serializer.sv
module afe_tx_serializer #(
  parameter  int unsigned SAMPLE_W = 14,
  parameter  int unsigned WORD_W   = 16,
  parameter  int unsigned GAP_W    = 8,
  localparam int unsigned SLOT     = WORD_W + GAP_W,
  localparam int unsigned CNT_W    = $clog2(2 * SLOT),
  localparam int unsigned IDX_W    = $clog2(WORD_W),
  localparam int unsigned PAD_W    = WORD_W - SAMPLE_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [CNT_W-1:0]    cnt_i,
  input  logic                boundary_i,
  input  logic [SAMPLE_W-1:0] sample_a_i,
  input  logic [SAMPLE_W-1:0] sample_b_i,
  output logic                sdo_o
);
  logic [1:0][SAMPLE_W-1:0] hold_q;
  logic                     in_b;
  logic [CNT_W-1:0]         pos;
  logic [WORD_W-1:0]        word;
  logic [IDX_W-1:0]         idx;
  logic                     bit_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         hold_q <= '0;
    else if (boundary_i) hold_q <= {sample_b_i, sample_a_i};
  end

  always_comb begin
    in_b  = cnt_i >= CNT_W'(SLOT);
    pos   = in_b ? cnt_i - CNT_W'(SLOT) : cnt_i;
    word  = {hold_q[in_b], {PAD_W{1'b0}}};
    idx   = IDX_W'(CNT_W'(WORD_W - 1) - pos);
    bit_d = (pos < CNT_W'(WORD_W)) ? word[idx] : 1'b1;
  end

  // launch on falling edge, half a bit ahead of the receiver's sampling edge
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sdo_o <= 1'b0;
    else         sdo_o <= bit_d;
  end

  AST_PAD_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pos >= CNT_W'(SAMPLE_W) && pos < CNT_W'(WORD_W)) |-> !sdo_o); // R3
  AST_GAP_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pos >= CNT_W'(WORD_W)) |-> sdo_o); // R4
endmodule

// File: rtl/afe_ctrl_decoder.sv
module afe_ctrl_decoder
  import afe_port_pkg::*;
#(
  parameter  int unsigned WORD_W    = 16,
  parameter  int unsigned FRAME_LEN = 48,
  localparam int unsigned CNT_W     = $clog2(FRAME_LEN),
  localparam int unsigned EN_B      = WORD_W - 1,
  localparam int unsigned LV_H      = WORD_W - 2,
  localparam int unsigned LV_L      = WORD_W - 3,
  localparam int unsigned G_H       = WORD_W - 4,
  localparam int unsigned G_L       = WORD_W - 6,
  localparam int unsigned LB_B      = WORD_W - 7,
  localparam int unsigned BO_B      = WORD_W - 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sdi_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             boundary_i,
  output ctrl_t            ctrl_o
);
  logic [WORD_W-1:0] shift_q;
  logic [2:0]        gcode;
  ctrl_t             dec;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       shift_q <= '0;
    else if (cnt_i < CNT_W'(WORD_W))   shift_q <= {shift_q[WORD_W-2:0], sdi_i};
  end

  always_comb begin
    gcode         = shift_q[G_H:G_L];
    dec.tx_en     = shift_q[EN_B];
    dec.loopback  = shift_q[LB_B];
    dec.boost     = shift_q[BO_B];
    dec.gain_rsvd = gcode > 3'd4;
    dec.gain_db   = dec.gain_rsvd ? '0 : GAIN_W'(gcode) * GAIN_W'(3);
    // Gray-ordered levels
    unique case (shift_q[LV_H:LV_L])
      2'b00:   dec.tx_level = 3'b101;
      2'b01:   dec.tx_level = 3'b111;
      2'b11:   dec.tx_level = 3'b001;
      default: dec.tx_level = 3'b011;
    endcase
    if (!dec.tx_en) dec.tx_level = 3'b000;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         ctrl_o <= '0;
    else if (boundary_i) ctrl_o <= dec;
  end

  AST_CTRL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !boundary_i |=> $stable(ctrl_o)); // R7
  AST_RSVD_GAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_o.gain_rsvd |-> (ctrl_o.gain_db == '0)); // R10
endmodule

// File: rtl/afe_serial_port.sv
module afe_serial_port
  import afe_port_pkg::*;
#(
  parameter  int unsigned SMP_W  = SAMPLE_W,
  parameter  int unsigned WRD_W  = WORD_W,
  parameter  int unsigned GAP_N  = GAP_W,
  localparam int unsigned FLEN   = 2 * (WRD_W + GAP_N),
  localparam int unsigned CNT_W  = $clog2(FLEN)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              baud_i,
  input  logic [SMP_W-1:0]  sample_a_i,
  input  logic [SMP_W-1:0]  sample_b_i,
  input  logic              sdi_i,
  output logic              sdo_o,
  output logic              sync_err_o,
  output logic              tx_en_o,
  output logic [2:0]        tx_level_o,
  output logic [GAIN_W-1:0] rx_gain_db_o,
  output logic              gain_rsvd_o,
  output logic              loopback_o,
  output logic              boost_o
);
  logic [CNT_W-1:0] cnt;
  logic             boundary;
  ctrl_t            ctrl;

  afe_frame_timer #(.FRAME_LEN(FLEN)) u_timer (
    .clk_i, .rst_ni, .baud_i,
    .cnt_o(cnt), .boundary_o(boundary), .sync_err_o
  );

  afe_tx_serializer #(.SAMPLE_W(SMP_W), .WORD_W(WRD_W), .GAP_W(GAP_N)) u_ser (
    .clk_i, .rst_ni, .cnt_i(cnt), .boundary_i(boundary),
    .sample_a_i, .sample_b_i, .sdo_o
  );

  afe_ctrl_decoder #(.WORD_W(WRD_W), .FRAME_LEN(FLEN)) u_dec (
    .clk_i, .rst_ni, .sdi_i, .cnt_i(cnt), .boundary_i(boundary), .ctrl_o(ctrl)
  );

  assign tx_en_o      = ctrl.tx_en;
  assign tx_level_o   = ctrl.tx_level;
  assign rx_gain_db_o = ctrl.gain_db;
  assign gain_rsvd_o  = ctrl.gain_rsvd;
  assign loopback_o   = ctrl.loopback;
  assign boost_o      = ctrl.boost;
endmodule

// File: tb/afe_serial_port_bench.sv
module afe_serial_port_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        baud_i = 1'b0;
  logic [13:0] sample_a_i = '0;
  logic [13:0] sample_b_i = '0;
  logic        sdi_i = 1'b0;
  logic        sdo_o, sync_err_o, tx_en_o, gain_rsvd_o, loopback_o, boost_o;
  logic [2:0]  tx_level_o;
  logic [3:0]  rx_gain_db_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  afe_serial_port u_afe_serial_port (
    .clk_i, .rst_ni, .baud_i, .sample_a_i, .sample_b_i, .sdi_i,
    .sdo_o, .sync_err_o, .tx_en_o, .tx_level_o, .rx_gain_db_o,
    .gain_rsvd_o, .loopback_o, .boost_o
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic exp_bit(input logic [13:0] a, input logic [13:0] b, input int k);
    logic [15:0] wa, wb;
    wa = {a, 2'b00};
    wb = {b, 2'b00};
    if (k < 16) return wa[15-k];
    if (k < 24) return 1'b1;
    if (k < 40) return wb[39-k];
    return 1'b1;
  endfunction

  function automatic string tag(input int k);
    if (k == 0) return "R1";
    if ((k >= 14 && k < 16) || (k >= 38 && k < 40)) return "R3";
    if (k < 16) return "R2";
    if (k < 24 || k >= 40) return "R4";
    return "R6";
  endfunction

  // starts just after the edge that set count 0
  task automatic run_frame(input logic [15:0] cw, input logic [13:0] ea, input logic [13:0] eb,
                           input logic [13:0] na, input logic [13:0] nb,
                           input bit raise_baud, input bit err_first);
    for (int k = 0; k < 48; k++) begin
      #2;
      sdi_i = (k < 16) ? cw[15-k] : 1'b0;
      if (k == 5) begin sample_a_i = na; sample_b_i = nb; end
      if (k == 3) baud_i = 1'b0;
      if (k == 46 && raise_baud) baud_i = 1'b1;
      if (k == 24) chk(sdo_o === 1'b1, "R5", 32'(sdo_o), 32'd1);
      #13;
      chk(sdo_o === exp_bit(ea, eb, k), tag(k), 32'(sdo_o), 32'(exp_bit(ea, eb, k)));
      chk(sync_err_o === (k == 0 && err_first), "R13", 32'(sync_err_o), 32'(k == 0 && err_first));
      @(posedge clk_i);
    end
  endtask

  task automatic check_ctrl(input logic [15:0] cw);
    logic [2:0] lvl, g;
    #1;
    g = cw[12:10];
    case (cw[14:13])
      2'b00: lvl = 3'b101;
      2'b01: lvl = 3'b111;
      2'b11: lvl = 3'b001;
      default: lvl = 3'b011;
    endcase
    if (!cw[15]) lvl = 3'b000;
    chk(tx_en_o === cw[15], "R8", 32'(tx_en_o), 32'(cw[15]));
    chk(tx_level_o === lvl, "R9", 32'(tx_level_o), 32'(lvl));
    chk(gain_rsvd_o === (g > 4), "R10", 32'(gain_rsvd_o), 32'(g > 4));
    chk(rx_gain_db_o === ((g > 4) ? 4'd0 : 4'(g * 3)), "R10", 32'(rx_gain_db_o),
        32'((g > 4) ? 0 : g * 3));
    chk(loopback_o === cw[9], "R11", 32'(loopback_o), 32'(cw[9]));
    chk(boost_o === cw[8], "R11", 32'(boost_o), 32'(cw[8]));
  endtask

  task automatic test_reset();
    repeat (3) @(posedge clk_i);
    chk(sdo_o === 1'b0 && sync_err_o === 1'b0, "R1", {30'd0, sdo_o, sync_err_o}, 32'd0);
    chk({tx_en_o, tx_level_o, rx_gain_db_o, gain_rsvd_o, loopback_o, boost_o} === '0, "R8",
        32'({tx_en_o, tx_level_o, rx_gain_db_o, gain_rsvd_o, loopback_o, boost_o}), 32'd0);
    #5 rst_ni = 1'b1;
    sample_a_i = 14'h1FFF;
    sample_b_i = 14'h2000;
    repeat (48) @(posedge clk_i);
  endtask

  task automatic test_decode_frames();
    run_frame(16'b1_00_000_1_0_00000000, 14'h1FFF, 14'h2000, 14'h0000, 14'h3FFF, 0, 0);
    check_ctrl(16'b1_00_000_1_0_00000000);
    run_frame(16'b1_01_001_0_1_00000000, 14'h0000, 14'h3FFF, 14'h1555, 14'h0AAA, 0, 0);
    check_ctrl(16'b1_01_001_0_1_00000000);
    run_frame(16'b1_11_100_0_0_00000000, 14'h1555, 14'h0AAA, 14'h2AAA, 14'h0001, 0, 0);
    check_ctrl(16'b1_11_100_0_0_00000000);
    run_frame(16'b0_10_101_1_1_00000000, 14'h2AAA, 14'h0001, 14'h0F0F, 14'h30F0, 0, 0);
    check_ctrl(16'b0_10_101_1_1_00000000);
    run_frame(16'b1_10_011_1_0_00000000, 14'h0F0F, 14'h30F0, 14'h1234, 14'h0567, 0, 0);
    check_ctrl(16'b1_10_011_1_0_00000000);
  endtask

  task automatic test_low_byte_ignored();
    logic [11:0] prev;
    prev = {tx_en_o, tx_level_o, rx_gain_db_o, gain_rsvd_o, loopback_o, boost_o};
    run_frame(16'b1_10_011_1_0_10100101, 14'h1234, 14'h0567, 14'h0100, 14'h3E00, 0, 0);
    #1;
    chk({tx_en_o, tx_level_o, rx_gain_db_o, gain_rsvd_o, loopback_o, boost_o} === prev, "R7",
        32'({tx_en_o, tx_level_o, rx_gain_db_o, gain_rsvd_o, loopback_o, boost_o}), 32'(prev));
  endtask

  task automatic test_baud_aligned();
    run_frame(16'b1_11_010_1_1_00000000, 14'h0100, 14'h3E00, 14'h0333, 14'h3CCC, 1, 0);
    #1;
    chk(sync_err_o === 1'b0, "R12", 32'(sync_err_o), 32'd0);
    chk(tx_level_o === 3'b001 && loopback_o === 1'b1, "R12", 32'({tx_level_o, loopback_o}), 32'h3);
    run_frame(16'b1_11_010_1_1_00000000, 14'h0333, 14'h3CCC, 14'h0333, 14'h3CCC, 0, 0);
    check_ctrl(16'b1_11_010_1_1_00000000);
  endtask

  task automatic test_baud_misaligned();
    for (int k = 0; k < 22; k++) begin
      #2;
      sdi_i = 1'b0;
      if (k == 5) begin sample_a_i = 14'h2001; sample_b_i = 14'h1FFE; end
      if (k == 20) baud_i = 1'b1;
      #13;
      chk(sync_err_o === 1'b0, "R13", 32'(sync_err_o), 32'd0);
      @(posedge clk_i);
    end
    #1;
    chk(sync_err_o === 1'b1, "R13", 32'(sync_err_o), 32'd1);
    chk(loopback_o === 1'b0 && tx_en_o === 1'b0, "R12", 32'({loopback_o, tx_en_o}), 32'd0);
    run_frame(16'b1_00_010_0_0_00000000, 14'h2001, 14'h1FFE, 14'h0000, 14'h0000, 0, 1);
    check_ctrl(16'b1_00_010_0_0_00000000);
  endtask

  initial begin
    test_reset();
    test_decode_frames();
    test_low_byte_ignored();
    test_baud_aligned();
    test_baud_misaligned();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule